// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a single-port synchronous static memory. Each word holds two 9-bit lanes, and each lane is eight data bits plus one parity bit, for 18 bits in all. The depth is set by a parameter. Every control input is sampled on the rising clock edge. An access starts when one of two address strobes loads a new external address, either the processor strobe or the controller strobe. Three chip enables decide at that load whether the block is selected. After the load, an advance input steps a two-bit burst counter, and a static mode input sets the burst order to linear or interleaved.

Writes come from a global write input, which writes the whole word, or from per-lane selects that are qualified by a byte-write enable. Read data is registered and returned one cycle after the address edge, as a data bus with a valid flag. An asynchronous output enable gates that pair. The valid flag is also suppressed on the first read after a deselected cycle.

Top module: `sync_burst_sram`

## Requirements
- R1: When a strobe load happens and all three chip enables are active (`ce1_n_i` low, `ce2_i` high, `ce3_n_i` low), the address is captured and that edge accesses `addr_i`.
- R2: If both strobes are low and `ce1_n_i` is low, only the processor strobe is acted on. A processor-strobe load is always a read, so the write controls are ignored in that cycle.
- R3: The processor strobe is ignored while `ce1_n_i` is high. If the controller strobe is high as well, the current selection and burst carry on unchanged.
- R4: The chip enables are sampled only on a strobe load. Changing them between loads has no effect on an ongoing burst.
- R5: A strobe load with any chip enable inactive deselects the block. While deselected, no read or write takes place and the advance input has no effect.
- R6: While selected, a low `glob_wr_n_i` writes all 18 bits, whatever `byte_sel_n_i` and `byte_wr_en_n_i` hold.
- R7: While selected, with `glob_wr_n_i` high and `byte_wr_en_n_i` low, lane k (bits 9k+8:9k, parity in bit 9k+8) is written when `byte_sel_n_i[k]` is low. When no lane is written, the cycle is a read.
- R8: A read at a rising edge returns the data of the address accessed at that edge, on `rdata_o` with `rvalid_o` high, during the following cycle.
- R9: On each edge with no load, the block selected and `adv_n_i` low, the burst step increments modulo 4. The low two address bits are base+step when `burst_lin_i` is 1 and base XOR step when it is 0. The upper bits stay at the loaded value. With `adv_n_i` high, the address is held.
- R10: While `oe_n_i` is high, `rvalid_o` is low and `rdata_o` is zero. This gating is combinational.
- R11: A read whose preceding cycle was deselected, including the first cycle after reset, yields `rvalid_o` low and `rdata_o` zero.
- R12: After reset the block is deselected, `rvalid_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 18 | Write data, two 9-bit lanes |
| byte_sel_n_i | input | 2 | Lane write selects, active low |
| byte_wr_en_n_i | input | 1 | Qualifier for the lane selects, active low |
| glob_wr_n_i | input | 1 | Whole-word write, active low |
| ce1_n_i | input | 1 | Chip enable one, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable two, active high |
| ce3_n_i | input | 1 | Chip enable three, active low |
| ads_proc_n_i | input | 1 | Processor address strobe, active low, higher priority |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved; static |
| rdata_o | output | 18 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
A wrong selection flag or burst step shows up at the ports in the cycle after the faulty edge. It appears either as a valid flag that is missing or should not be there, or as data from the wrong word, because every access edge is followed by one observed output cycle. A wrong write-lane decode is hidden until that word is read back. The random phase therefore keeps addresses in a small window, so most writes are re-read within a few dozen cycles. Priority, enable sampling and masking errors are caught through the valid flag and through reads that show whether a write landed.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic       sel;
        logic       rd;
        lane_mask_t wr;
    } access_t;

    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       lin);
        return lin ? (base + step) : (base ^ step);
    endfunction

    function automatic logic enables_ok(input logic c1n, input logic c2,
                                        input logic c3n);
        return !c1n && c2 && !c3n;
    endfunction

endpackage

// File: rtl/sram_addr_ctrl.sv
module sram_addr_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              ce3_n_i,
    input  logic              ads_p_n_i,
    input  logic              ads_c_n_i,
    input  logic              adv_n_i,
    input  logic              lin_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              acc_sel_o,
    output logic              proc_ld_o,
    output logic              sel_q_o,
    output logic [ADDR_W-1:0] base_q_o
);
    localparam int HI = ADDR_W - 1;

    logic              sel_q, sel_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        step_q, step_d;
    logic              proc_ld, ctrl_ld, load;

    always_comb begin
        proc_ld = !ads_p_n_i && !ce1_n_i;
        ctrl_ld = !ads_c_n_i && !proc_ld;
        load    = proc_ld || ctrl_ld;
        if (load) begin
            sel_d  = enables_ok(ce1_n_i, ce2_i, ce3_n_i);
            base_d = addr_i;
            step_d = 2'd0;
        end else begin
            sel_d  = sel_q;
            base_d = base_q;
            step_d = (sel_q && !adv_n_i) ? step_q + 2'd1 : step_q;
        end
    end

    assign acc_addr_o = {base_d[HI:2], burst_lo(base_d[1:0], step_d, lin_i)};
    assign acc_sel_o  = sel_d;
    assign proc_ld_o  = proc_ld;
    assign sel_q_o    = sel_q;
    assign base_q_o   = base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            base_q <= '0;
            step_q <= 2'd0;
        end else begin
            sel_q  <= sel_d;
            base_q <= base_d;
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/sram_wr_dec.sv
module sram_wr_dec
    import sram_pkg::*;
(
    input  logic       glob_wr_n_i,
    input  logic       bwe_n_i,
    input  lane_mask_t bsel_n_i,
    input  logic       proc_ld_i,
    output lane_mask_t lanes_o
);
    always_comb begin
        if (proc_ld_i)
            lanes_o = '0;
        else if (!glob_wr_n_i)
            lanes_o = '1;
        else if (!bwe_n_i)
            lanes_o = ~bsel_n_i;
        else
            lanes_o = '0;
    end
endmodule

// File: rtl/sram_core.sv
module sram_core
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    input  lane_mask_t        we_i,
    input  logic              rd_i,
    output word_t             rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (we_i[g])
                mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (rd_i)
                q <= mem[addr_i];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [17:0]       wdata_i,
    input  logic [1:0]        byte_sel_n_i,
    input  logic              byte_wr_en_n_i,
    input  logic              glob_wr_n_i,
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              ce3_n_i,
    input  logic              ads_proc_n_i,
    input  logic              ads_ctrl_n_i,
    input  logic              adv_n_i,
    input  logic              oe_n_i,
    input  logic              burst_lin_i,
    output logic [17:0]       rdata_o,
    output logic              rvalid_o
);
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_sel, proc_ld, sel_st;
    logic [ADDR_W-1:0] base_st;
    lane_mask_t        lanes;
    access_t           acc;
    word_t             core_q;
    logic              pend_q, first_q;

    sram_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .ce1_n_i   (ce1_n_i),
        .ce2_i     (ce2_i),
        .ce3_n_i   (ce3_n_i),
        .ads_p_n_i (ads_proc_n_i),
        .ads_c_n_i (ads_ctrl_n_i),
        .adv_n_i   (adv_n_i),
        .lin_i     (burst_lin_i),
        .acc_addr_o(acc_addr),
        .acc_sel_o (acc_sel),
        .proc_ld_o (proc_ld),
        .sel_q_o   (sel_st),
        .base_q_o  (base_st)
    );

    sram_wr_dec u_wdec (
        .glob_wr_n_i(glob_wr_n_i),
        .bwe_n_i    (byte_wr_en_n_i),
        .bsel_n_i   (byte_sel_n_i),
        .proc_ld_i  (proc_ld),
        .lanes_o    (lanes)
    );

    always_comb begin
        acc.sel = acc_sel;
        acc.wr  = acc_sel ? lanes : '0;
        acc.rd  = acc_sel && (lanes == '0);
    end

    sram_core #(.ADDR_W(ADDR_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .addr_i (acc_addr),
        .wdata_i(wdata_i),
        .we_i   (acc.wr),
        .rd_i   (acc.rd),
        .rdata_o(core_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            pend_q  <= acc.rd;
            first_q <= !sel_st;
        end
    end

    assign rvalid_o = pend_q && !first_q && !oe_n_i;
    assign rdata_o  = rvalid_o ? core_q : '0;

endmodule

module sram_burst_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              oe_n_i,
    input logic              ads_proc_n_i,
    input logic              ads_ctrl_n_i,
    input logic              ce1_n_i,
    input logic              ce2_i,
    input logic              ce3_n_i,
    input logic              rvalid_o,
    input logic [17:0]       rdata_o,
    input logic              sel_st,
    input logic [ADDR_W-1:0] base_st
);
    logic loading, enables_on;
    assign loading    = (!ads_proc_n_i && !ce1_n_i) || !ads_ctrl_n_i;
    assign enables_on = !ce1_n_i && ce2_i && !ce3_n_i;

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !rvalid_o);

    assert_zero_data_R10: assert property (@(posedge clk) disable iff (rst)
        !rvalid_o |-> (rdata_o == 18'd0));

    assert_mask_after_desel_R11: assert property (@(posedge clk) disable iff (rst)
        !sel_st |=> !rvalid_o);

    assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!ads_proc_n_i && ce1_n_i && ads_ctrl_n_i) |=> ($stable(sel_st) && $stable(base_st)));

    assert_ce_only_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        !loading |=> $stable(sel_st));

    assert_desel_load_R5: assert property (@(posedge clk) disable iff (rst)
        (loading && !enables_on) |=> !sel_st);

endmodule

bind sync_burst_sram sram_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .oe_n_i      (oe_n_i),
    .ads_proc_n_i(ads_proc_n_i),
    .ads_ctrl_n_i(ads_ctrl_n_i),
    .ce1_n_i     (ce1_n_i),
    .ce2_i       (ce2_i),
    .ce3_n_i     (ce3_n_i),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o),
    .sel_st      (sel_st),
    .base_st     (base_st)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] a;
    logic [17:0]       wd;
    logic [1:0]        bs_n;
    logic              bwe_n, gw_n, c1n, c2, c3n, pn, cn, avn, oen, lin;
    logic [17:0]       rdata;
    logic              rvalid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [17:0]       mem [DEPTH];
    logic              m_sel, m_pend, m_first;
    logic [ADDR_W-1:0] m_base;
    logic [1:0]        m_step;
    logic [17:0]       m_data;
    string             last_tag;

    sync_burst_sram #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .addr_i(a), .wdata_i(wd), .byte_sel_n_i(bs_n),
        .byte_wr_en_n_i(bwe_n), .glob_wr_n_i(gw_n), .ce1_n_i(c1n), .ce2_i(c2),
        .ce3_n_i(c3n), .ads_proc_n_i(pn), .ads_ctrl_n_i(cn), .adv_n_i(avn),
        .oe_n_i(oen), .burst_lin_i(lin), .rdata_o(rdata), .rvalid_o(rvalid)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic idle();
        pn = 1; cn = 1; avn = 1; gw_n = 1; bwe_n = 1; bs_n = 2'b11;
        c1n = 0; c2 = 1; c3n = 0; oen = 0;
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [1:0] s, input logic l);
        logic [1:0] lo;
        lo = l ? b[1:0] + s : b[1:0] ^ s;
        return {b[ADDR_W-1:2], lo};
    endfunction

    function automatic string auto_tag();
        logic pl, ld;
        pl = !pn && !c1n;
        ld = pl || !cn;
        if (pl && (!gw_n || !bwe_n)) return "R2";
        if (!pn && c1n) return "R3";
        if (ld && !(!c1n && c2 && !c3n)) return "R5";
        if (!ld && m_sel && !(!c1n && c2 && !c3n)) return "R4";
        if (!ld && m_sel && !avn) return "R9";
        if (!gw_n) return "R6";
        if (!bwe_n) return "R7";
        if (ld) return "R1";
        return "R8";
    endfunction

    // Reference model of one rising edge, from the requirements.
    task automatic model_edge();
        logic pl, ld, nsel;
        logic [ADDR_W-1:0] nb, ea;
        logic [1:0] ns, wl;
        pl = !pn && !c1n;
        ld = pl || !cn;
        if (ld) begin
            nsel = !c1n && c2 && !c3n; nb = a; ns = 0;
        end else begin
            nsel = m_sel; nb = m_base;
            ns = (m_sel && !avn) ? m_step + 2'd1 : m_step;
        end
        ea = exp_addr(nb, ns, lin);
        wl = pl ? 2'b00 : (!gw_n ? 2'b11 : (!bwe_n ? ~bs_n : 2'b00));
        m_first = !m_sel;
        m_pend  = nsel && (wl == 0);
        if (m_pend) m_data = mem[ea];
        if (nsel) begin
            if (wl[0]) mem[ea][8:0]  = wd[8:0];
            if (wl[1]) mem[ea][17:9] = wd[17:9];
        end
        m_sel = nsel; m_base = nb; m_step = ns;
    endtask

    task automatic compare();
        logic ev;
        logic [17:0] ed;
        string t;
        ev = m_pend && !m_first && !oen;
        ed = ev ? m_data : 18'd0;
        t  = last_tag;
        if (m_pend && oen) t = "R10";
        else if (m_pend && m_first) t = "R11";
        checks++;
        if (rvalid !== ev || rdata !== ed) begin
            errors++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     t, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic cyc(input string tag);
        last_tag = (tag == "") ? auto_tag() : tag;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        idle(); a = '0; wd = '0; lin = 1;
        m_sel = 0; m_pend = 0; m_first = 0; m_base = '0; m_step = 0; m_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        checks++;
        if (rvalid !== 1'b0 || rdata !== 18'd0) begin
            errors++;
            $display("FAIL R12: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end
        // R6: fill memory with whole-word writes through the controller strobe
        for (int i = 0; i < DEPTH; i++) begin
            idle(); cn = 0; gw_n = 0; a = i[ADDR_W-1:0];
            wd = {i[8:0] ^ 9'h155, i[8:0]};
            cyc("R6");
        end
        // R1/R11: load and read; first read after deselect is masked
        idle(); cn = 0; c3n = 1; a = 8'h10; cyc("R5");
        idle(); cn = 0; a = 8'h12; cyc("R11");
        idle(); cyc("R8");
        // R9: linear burst from low bits 2
        idle(); cn = 0; a = 8'h22; lin = 1; cyc("R1");
        for (int k = 0; k < 5; k++) begin idle(); avn = 0; cyc("R9"); end
        // R9: interleaved burst from low bits 1
        idle(); cn = 0; a = 8'h35; lin = 0; cyc("R1");
        for (int k = 0; k < 5; k++) begin idle(); avn = 0; cyc("R9"); end
        lin = 1;
        // R2: both strobes low, write request ignored
        idle(); pn = 0; cn = 0; gw_n = 0; wd = 18'h3FFFF; a = 8'h40; cyc("R2");
        idle(); cn = 0; a = 8'h40; cyc("R2");
        idle(); cyc("R2");
        // R3: processor strobe with ce1 high is ignored, burst continues
        idle(); pn = 0; c1n = 1; avn = 0; a = 8'h77; cyc("R3");
        idle(); cyc("R3");
        // R4: enables dropped mid-burst have no effect
        idle(); c2 = 0; c3n = 1; avn = 0; cyc("R4");
        idle(); c1n = 1; cyc("R4");
        // R5: deselected block ignores advance and writes
        idle(); cn = 0; c2 = 0; a = 8'h50; cyc("R5");
        idle(); avn = 0; gw_n = 0; wd = 18'h0; cyc("R5");
        idle(); avn = 0; cyc("R5");
        // R7: lane writes, then read back
        idle(); cn = 0; a = 8'h51; bwe_n = 0; bs_n = 2'b10; wd = 18'h2AAAA; cyc("R7");
        idle(); bwe_n = 0; bs_n = 2'b01; wd = 18'h15555; avn = 0; cyc("R7");
        idle(); bwe_n = 1; bs_n = 2'b00; gw_n = 1; cyc("R7");
        idle(); cn = 0; a = 8'h51; cyc("R7");
        idle(); avn = 0; cyc("R7");
        // R10: output enable high hides a read
        idle(); oen = 1; cyc("R10");
        idle(); cyc("R10");
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            a     = 8'(($urandom % 16) + ((n / 1000) * 16));
            wd    = 18'($urandom);
            pn    = ($urandom % 10) >= 3;
            cn    = ($urandom % 10) >= 3;
            c1n   = ($urandom % 100) < 15;
            c2    = ($urandom % 100) >= 10;
            c3n   = ($urandom % 100) < 10;
            avn   = $urandom % 2;
            gw_n  = ($urandom % 100) >= 15;
            bwe_n = ($urandom % 10) >= 3;
            bs_n  = 2'($urandom);
            oen   = ($urandom % 100) < 15;
            lin   = (n >= 2000);
            cyc("");
        end
        idle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule